// File: doc/BRIEF.md
# Weighted-Transition Scan Power Monitor

This block watches the bit stream that is shifted into a scan chain and rates each test pattern by the switching activity it causes during shifting. Two adjacent scan bits that differ form a transition. A transition that occurs early in the shift counts for more than one that occurs late, because it will be moved past more scan cells before the load completes. The block adds these weighted transitions into one metric per pattern. The metric is reported when the pattern is complete.

Across a whole test set, the block keeps the largest pattern metric seen and the sum of all the metrics. When the set is closed, a sequential divider turns the sum into the average metric per pattern. The peak and the average together give an estimate of peak and mean scan-in power. The block can sit beside a decompressor on the chip, or a testbench can use it to grade pattern orderings and fill choices.

Top module: `scan_wtm_monitor`

## Requirements
- R1: After reset, every output is zero: `pat_metric`, `pat_metric_vld`, `peak_metric`, `avg_metric`, `avg_done` and `avg_busy`.
- R2: A bit is taken only in a cycle where `scan_vld` is 1. A taken bit with `pat_first`=1 is position 1 of a new pattern and adds nothing to the metric. Cycles with `scan_vld`=0 have no effect, including cycles in the middle of a pattern.
- R3: Suppose a taken bit at position j+1 differs from the bit at position j, where 1 ≤ j ≤ PAT_LEN−1. That transition adds PAT_LEN−j to the pattern metric. Equal neighbours add 0. With the default PAT_LEN=16, the largest possible metric is 120.
- R4: `pat_metric_vld` is 1 for exactly one cycle: the cycle that follows the clock edge at which the PAT_LEN-th bit is taken. In that cycle `pat_metric` carries the finished metric. `pat_metric` then holds that value until the next pattern completes.
- R5: Taken bits are ignored when they have `pat_first`=0 and arrive after a pattern has completed, or before any pattern has started.
- R6: A taken bit with `pat_first`=1 in the middle of a pattern discards the partial pattern. The discarded pattern produces no pulse and no contribution to the set.
- R7: `peak_metric` is the largest metric completed in the current set. It changes in the same cycle as the `pat_metric_vld` pulse.
- R8: The cycle after `set_last`=1 is seen while idle, `avg_busy` rises. `avg_done` pulses exactly SUM_W+1 cycles after the `set_last` cycle, where SUM_W = ceil(log2(120·MAX_PATS+1)), which is 17 at the defaults. In the pulse cycle, `avg_metric` equals the floor of the set sum divided by the number of completed patterns.
- R9: Closing a set that holds no completed pattern gives an average of 0.
- R10: An accepted `set_last` clears the peak, the sum and the pattern count for the next set. A pattern that completes in the same cycle as `set_last` belongs to the set being closed.
- R11: `set_last` is ignored while `avg_busy` is 1. Patterns that complete during a division go into the new set.
- R12: `avg_metric` holds its value until the next `avg_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_vld | input | 1 | A scan bit is present this cycle |
| scan_bit | input | 1 | The scan bit value |
| pat_first | input | 1 | The present bit is position 1 of a pattern |
| set_last | input | 1 | Close the test set and compute its average |
| pat_metric | output | WTM_W (7) | Weighted transition metric of the last completed pattern |
| pat_metric_vld | output | 1 | One-cycle pulse: a new `pat_metric` |
| peak_metric | output | WTM_W (7) | Largest pattern metric in the current set |
| avg_metric | output | WTM_W (7) | Average metric of the last closed set |
| avg_done | output | 1 | One-cycle pulse: a new `avg_metric` |
| avg_busy | output | 1 | The divider is running |

## Verification
A wrong position count or a stale last bit makes the very next completed pattern report a wrong metric. It can also put the `pat_metric_vld` pulse in the wrong cycle. Either error shows at the ports at most PAT_LEN cycles after it happens. Damage to the peak register shows at once on `peak_metric`. Damage to the sum or the count stays hidden until the set is closed, and then shows as a wrong `avg_metric`. Because of that, the bench compares every output against a behavioural model on every clock. It also closes several sets, including one that closes in the same cycle as a pattern completes and one with no patterns at all.

// File: rtl/scan_wtm_pkg.sv
package scan_wtm_pkg;

  // Worst-case metric of one pattern: a transition at every position.
  function automatic int unsigned wtm_worst(input int unsigned n);
    return (n * (n - 1)) / 2;
  endfunction

  // Weight of a transition between position j and j+1 of an n-bit pattern.
  function automatic int unsigned wtm_weight(input int unsigned n, input int unsigned j);
    return n - j;
  endfunction

  // Bits needed to hold values 0..v.
  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/wtm_pattern_acc.sv
module wtm_pattern_acc
  import scan_wtm_pkg::*;
#(
  parameter int unsigned PAT_LEN = 16,
  parameter int unsigned POS_W   = 5,
  parameter int unsigned WTM_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_vld,
  input  logic             scan_bit,
  input  logic             pat_first,
  output logic             pat_done,
  output logic [WTM_W-1:0] pat_final,
  output logic [WTM_W-1:0] wtm_q,
  output logic             wtm_vld_q
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(PAT_LEN);
  localparam logic [POS_W-1:0] PEN_POS  = POS_W'(PAT_LEN - 1);
  localparam int unsigned      WTM_MAX  = wtm_worst(PAT_LEN);

  logic [POS_W-1:0] pos_q;
  logic             last_q;
  logic [WTM_W-1:0] run_q;

  // Named internal events
  logic             step_ok;
  logic             toggle;
  logic [WTM_W-1:0] weight;
  logic [WTM_W-1:0] run_nx;

  assign step_ok   = scan_vld && !pat_first && (pos_q != '0) && (pos_q < LAST_POS);
  assign toggle    = step_ok && (scan_bit != last_q);
  assign weight    = WTM_W'(wtm_weight(PAT_LEN, 32'(pos_q)));
  assign run_nx    = toggle ? (run_q + weight) : run_q;
  assign pat_done  = step_ok && (pos_q == PEN_POS);
  assign pat_final = run_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q     <= '0;
      last_q    <= 1'b0;
      run_q     <= '0;
      wtm_q     <= '0;
      wtm_vld_q <= 1'b0;
    end else begin
      if (scan_vld && pat_first) begin
        pos_q  <= POS_W'(1);
        last_q <= scan_bit;
        run_q  <= '0;
      end else if (step_ok) begin
        pos_q  <= pos_q + POS_W'(1);
        last_q <= scan_bit;
        run_q  <= run_nx;
      end
      wtm_vld_q <= pat_done;
      if (pat_done) wtm_q <= run_nx;
    end
  end

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wtm_vld_q |=> !wtm_vld_q);
  assert_metric_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wtm_vld_q |-> (32'(wtm_q) <= WTM_MAX));
  assert_pos_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST_POS);
  assert_first_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_vld && pat_first) |=> (run_q == '0));

endmodule

// File: rtl/wtm_set_stats.sv
module wtm_set_stats #(
  parameter int unsigned WTM_W = 7,
  parameter int unsigned SUM_W = 17,
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pat_done,
  input  logic [WTM_W-1:0] pat_final,
  input  logic             clr,
  output logic [WTM_W-1:0] peak_q,
  output logic [SUM_W-1:0] sum_nx,
  output logic [CNT_W-1:0] cnt_nx
);

  logic [SUM_W-1:0] sum_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WTM_W-1:0] peak_nx;

  // The completing pattern is folded in before any clear, so it joins the closing set.
  assign sum_nx  = pat_done ? (sum_q + SUM_W'(pat_final)) : sum_q;
  assign cnt_nx  = pat_done ? (cnt_q + CNT_W'(1)) : cnt_q;
  assign peak_nx = (pat_done && (pat_final > peak_q)) ? pat_final : peak_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sum_q  <= '0;
      cnt_q  <= '0;
      peak_q <= '0;
    end else begin
      sum_q  <= sum_nx;
      cnt_q  <= cnt_nx;
      peak_q <= peak_nx;
    end
  end

  assert_peak_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (peak_q >= $past(peak_q)));
  assert_peak_covers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_done && !clr) |=> (peak_q >= $past(pat_final)));
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (peak_q == '0));

endmodule

// File: rtl/wtm_avg_div.sv
module wtm_avg_div
  import scan_wtm_pkg::*;
#(
  parameter int unsigned SUM_W = 17,
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SUM_W-1:0] dividend,
  input  logic [CNT_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [SUM_W-1:0] quot
);

  localparam int unsigned STEP_W = bits_for(SUM_W);

  logic [STEP_W-1:0] step_q;
  logic [SUM_W-1:0]  dvd_q;
  logic [CNT_W-1:0]  rem_q;
  logic [CNT_W-1:0]  div_q;

  // One restoring step per cycle
  logic [CNT_W:0]    trial;
  logic              fits;
  logic [CNT_W:0]    trial_sub;
  logic [SUM_W-1:0]  dvd_nx;

  assign trial     = {rem_q, dvd_q[SUM_W-1]};
  assign fits      = trial >= {1'b0, div_q};
  assign trial_sub = trial - {1'b0, div_q};
  assign dvd_nx    = {dvd_q[SUM_W-2:0], fits};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
      dvd_q  <= '0;
      rem_q  <= '0;
      div_q  <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      quot   <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        rem_q  <= fits ? trial_sub[CNT_W-1:0] : trial[CNT_W-1:0];
        dvd_q  <= dvd_nx;
        step_q <= step_q - STEP_W'(1);
        if (step_q == STEP_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          quot <= (div_q == '0) ? '0 : dvd_nx;
        end
      end else if (start) begin
        dvd_q  <= dividend;
        div_q  <= divisor;
        rem_q  <= '0;
        step_q <= STEP_W'(SUM_W);
        busy   <= 1'b1;
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(quot) || done);

endmodule

// File: rtl/scan_wtm_monitor.sv
module scan_wtm_monitor
  import scan_wtm_pkg::*;
#(
  parameter int unsigned PAT_LEN  = 16,
  parameter int unsigned MAX_PATS = 1024,
  localparam int unsigned WTM_MAX = wtm_worst(PAT_LEN),
  localparam int unsigned WTM_W   = bits_for(WTM_MAX),
  localparam int unsigned POS_W   = bits_for(PAT_LEN),
  localparam int unsigned SUM_W   = bits_for(WTM_MAX * MAX_PATS),
  localparam int unsigned CNT_W   = bits_for(MAX_PATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_vld,
  input  logic             scan_bit,
  input  logic             pat_first,
  input  logic             set_last,
  output logic [WTM_W-1:0] pat_metric,
  output logic             pat_metric_vld,
  output logic [WTM_W-1:0] peak_metric,
  output logic [WTM_W-1:0] avg_metric,
  output logic             avg_done,
  output logic             avg_busy
);

  // Events between the pieces, named for the assertions
  logic             pat_done;
  logic [WTM_W-1:0] pat_final;
  logic             set_take;
  logic [SUM_W-1:0] sum_nx;
  logic [CNT_W-1:0] cnt_nx;
  logic [SUM_W-1:0] quot;

  assign set_take = set_last && !avg_busy;

  wtm_pattern_acc #(
    .PAT_LEN (PAT_LEN),
    .POS_W   (POS_W),
    .WTM_W   (WTM_W)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_vld  (scan_vld),
    .scan_bit  (scan_bit),
    .pat_first (pat_first),
    .pat_done  (pat_done),
    .pat_final (pat_final),
    .wtm_q     (pat_metric),
    .wtm_vld_q (pat_metric_vld)
  );

  wtm_set_stats #(
    .WTM_W (WTM_W),
    .SUM_W (SUM_W),
    .CNT_W (CNT_W)
  ) u_stats (
    .clk       (clk),
    .rst_n     (rst_n),
    .pat_done  (pat_done),
    .pat_final (pat_final),
    .clr       (set_take),
    .peak_q    (peak_metric),
    .sum_nx    (sum_nx),
    .cnt_nx    (cnt_nx)
  );

  wtm_avg_div #(
    .SUM_W (SUM_W),
    .CNT_W (CNT_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (set_take),
    .dividend (sum_nx),
    .divisor  (cnt_nx),
    .busy     (avg_busy),
    .done     (avg_done),
    .quot     (quot)
  );

  assign avg_metric = quot[WTM_W-1:0];

  assert_avg_fits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    avg_done |-> (32'(quot) <= WTM_MAX));
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_last && avg_busy) |=> (peak_metric >= $past(peak_metric)));
  assert_peak_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(peak_metric) <= WTM_MAX);

endmodule

// File: tb/scan_wtm_monitor_tb.sv
module scan_wtm_monitor_tb;

  localparam int N    = 16;
  localparam int MAXP = 1024;
  localparam int WMAX = N * (N - 1) / 2;
  localparam int SUMW = $clog2(WMAX * MAXP + 1);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_vld = 1'b0, scan_bit = 1'b0, pat_first = 1'b0, set_last = 1'b0;
  logic [6:0] pat_metric, peak_metric, avg_metric;
  logic       pat_metric_vld, avg_done, avg_busy;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit started = 0;

  always #4 clk = ~clk;

  scan_wtm_monitor #(.PAT_LEN(N), .MAX_PATS(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .scan_vld(scan_vld), .scan_bit(scan_bit),
    .pat_first(pat_first), .set_last(set_last), .pat_metric(pat_metric),
    .pat_metric_vld(pat_metric_vld), .peak_metric(peak_metric),
    .avg_metric(avg_metric), .avg_done(avg_done), .avg_busy(avg_busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_pos = 0, m_last = 0, m_run = 0, m_metric = 0, m_vld = 0, m_peak = 0;
  int m_sum = 0, m_cnt = 0, m_busy = 0, m_rem = 0, m_q = 0, m_avg = 0, m_done = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_pos = 0; m_last = 0; m_run = 0; m_metric = 0; m_vld = 0; m_peak = 0;
      m_sum = 0; m_cnt = 0; m_busy = 0; m_rem = 0; m_avg = 0; m_done = 0;
    end else begin
      m_vld = 0; m_done = 0;
      if (scan_vld) begin
        if (pat_first) begin
          m_pos = 1; m_last = scan_bit; m_run = 0;
        end else if (m_pos >= 1 && m_pos < N) begin
          if (int'(scan_bit) != m_last) m_run += N - m_pos;
          m_last = scan_bit;
          m_pos++;
          if (m_pos == N) begin
            m_metric = m_run; m_vld = 1;
            if (m_run > m_peak) m_peak = m_run;
            m_sum += m_run; m_cnt++;
          end
        end
      end
      if (m_busy != 0) begin
        m_rem--;
        if (m_rem == 0) begin m_busy = 0; m_done = 1; m_avg = m_q; end
      end else if (set_last) begin
        m_q = (m_cnt != 0) ? m_sum / m_cnt : 0;
        m_sum = 0; m_cnt = 0; m_peak = 0;
        m_busy = 1; m_rem = SUMW;
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R3 pat_metric", pat_metric, m_metric);
      chk("R4 pat_metric_vld", pat_metric_vld, m_vld);
      chk("R7 peak_metric", peak_metric, m_peak);
      chk("R12 avg_metric", avg_metric, m_avg);
      chk("R8 avg_done", avg_done, m_done);
      chk("R11 avg_busy", avg_busy, m_busy);
    end
  end

  task automatic idle();
    scan_vld = 0; pat_first = 0; scan_bit = 0; set_last = 0;
  endtask

  task automatic send_pat(input logic [N-1:0] v, input int len, input bit gap, input bit close_on_last);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      scan_vld = 1; pat_first = (i == 0); scan_bit = v[i];
      set_last = close_on_last && (i == len - 1);
      if (gap && i < len - 1) begin
        @(negedge clk);
        idle();
      end
    end
    @(negedge clk);
    idle();
  endtask

  task automatic wait_done();
    for (int k = 0; k < 60; k++) begin
      if (avg_done) break;
      @(negedge clk);
    end
  endtask

  int c0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    started = 1;
    // R1: reset state
    chk("R1 pat_metric", pat_metric, 0);
    chk("R1 peak_metric", peak_metric, 0);
    chk("R1 avg_metric", avg_metric, 0);
    chk("R1 flags", {pat_metric_vld, avg_done, avg_busy}, 0);

    // R5: bits before any start are ignored
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); scan_vld = 1; scan_bit = i[0];
    end
    @(negedge clk); idle();
    chk("R5 no pulse before start", pat_metric_vld, 0);
    chk("R5 peak untouched", peak_metric, 0);

    send_pat(16'h0000, N, 0, 0);
    chk("R3 flat pattern", pat_metric, 0);
    chk("R4 pulse", pat_metric_vld, 1);
    send_pat(16'hAAAA, N, 0, 0);
    chk("R3 all transitions", pat_metric, 120);
    chk("R7 peak rises", peak_metric, 120);
    send_pat(16'h0001, N, 0, 0);
    chk("R3 first transition weight", pat_metric, 15);
    chk("R7 peak kept", peak_metric, 120);
    // R2: gaps in scan_vld
    send_pat(16'h8000, N, 1, 0);
    chk("R2 gapped pattern", pat_metric, 1);
    @(negedge clk);
    chk("R4 single cycle pulse", pat_metric_vld, 0);
    // R5: extra bits after completion
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); scan_vld = 1; scan_bit = i[0];
    end
    @(negedge clk); idle();
    chk("R5 no pulse after complete", pat_metric_vld, 0);
    chk("R5 metric held", pat_metric, 1);
    // R6: restart mid-pattern
    send_pat(16'h5555, 7, 0, 0);
    chk("R6 partial no pulse", pat_metric_vld, 0);
    send_pat(16'hFFFF, N, 0, 0);
    chk("R6 restarted pattern", pat_metric, 0);

    // R8/R11: close set (0+120+15+1+0)/5 = 27; new pattern and ignored close while busy
    @(negedge clk); set_last = 1; c0 = cyc;
    send_pat(16'hAAAA, N, 0, 0);
    set_last = 1;
    @(negedge clk); idle();
    wait_done();
    chk("R8 latency", cyc - c0, SUMW + 1);
    chk("R8 average", avg_metric, 27);
    chk("R11 peak kept after ignored close", peak_metric, 120);

    // R10: close in the same cycle as completion: (120+1)/2 = 60
    send_pat(16'h8000, N, 0, 1);
    chk("R10 pattern reported", pat_metric, 1);
    chk("R10 peak cleared", peak_metric, 0);
    wait_done();
    chk("R10 average includes last", avg_metric, 60);
    repeat (5) @(negedge clk);
    chk("R12 average held", avg_metric, 60);

    // R9: empty set
    @(negedge clk); set_last = 1;
    @(negedge clk); idle();
    wait_done();
    chk("R9 empty set average", avg_metric, 0);
    chk("R9 done pulse", avg_done, 1);
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule